// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is a small counter fed from one external pin. It has two modes. In event mode it adds one to the count for each selected edge on the pin. In gated mode it adds one for every tick of a free-running divider while the pin sits at its active level, which turns the count into a measure of how long the pin was active. A single polarity input picks the counted edge in event mode and the active level in gated mode.

Software can load the count at any time. Loading 256 minus N makes the count wrap after N more increments. Two sticky flags record the wrap from all-ones to zero and the selected pin edge. Each flag has its own interrupt enable, and the two enabled flags are combined into one interrupt line. This suits short event counts as well as sorting wide pulses from narrow ones: a wide pulse reaches the wrap before the edge that ends it, and a narrow pulse does not.

The pin passes through a synchroniser before edge detection. Flags are cleared by writing a 1 to their clear bit.

Top module: `pulse_accum`

## Requirements
- R1: After reset the count is 0, both flags are 0 and the interrupt line is low.
- R2: Event mode is selected by mode 0. With polarity 0, each rising pin edge adds one to the count. The count changes on the third rising clock edge after the pin changes, because of a two-stage synchroniser.
- R3: In event mode with polarity 1, falling pin edges add one to the count and rising edges do not change it.
- R4: Gated mode is selected by mode 1. The count adds one on each divider tick while the synchronised pin is at its active level: high for polarity 0, low for polarity 1. Pin edges add nothing.
- R5: The divider ticks once every 64 clocks, counting from reset, whatever the pin, mode or enable. So any 64 consecutive clocks of active level give exactly one increment.
- R6: When an increment takes the count from 255 to 0, the overflow flag sets. Loading 256-N therefore sets the flag after N increments.
- R7: The edge flag sets on the counted edge in event mode. In gated mode it sets on the edge that ends the active level: the falling edge for polarity 0, the rising edge for polarity 1.
- R8: A count write loads the write data and wins over an increment in the same cycle. That cycle raises no overflow.
- R9: Both flags are sticky. Clear bit 0 clears the overflow flag and clear bit 1 clears the edge flag. If a flag sets and clears in the same cycle, the set wins.
- R10: The interrupt line is high exactly when (overflow flag and its enable) or (edge flag and its enable).
- R11: While enable is low the count does not move and no flag sets. Count writes and flag clears still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous pin being counted or timed |
| enable_i | input | 1 | Turns counting and flag setting on |
| mode_i | input | 1 | 0 = event counting, 1 = gated time accumulation |
| pol_i | input | 1 | 0 = rising edge / high active, 1 = falling edge / low active |
| cnt_wr_i | input | 1 | Load strobe for the count |
| cnt_wdata_i | input | 8 | Value to load into the count |
| flag_clr_i | input | 2 | Write-1-to-clear: bit 0 overflow, bit 1 edge |
| ovf_ie_i | input | 1 | Interrupt enable for the overflow flag |
| edge_ie_i | input | 1 | Interrupt enable for the edge flag |
| cnt_o | output | 8 | Current count |
| ovf_flag_o | output | 1 | Sticky wrap flag |
| edge_flag_o | output | 1 | Sticky pin edge flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench uses the default parameters: an 8-bit count, a divide-by-64 tick and a two-stage synchroniser. With these defaults a full gated wrap takes only a few hundred ticks, so the overflow path in gated mode is covered as well as the one in event mode. Active windows that are multiples of 64 clocks give exact expected counts even though the divider phase is not reset by the pin. The bench also lines up a count write, or a flag clear, with the clock edge on which an increment lands. This tests both same-cycle priority rules exactly.

// File: rtl/pulse_accum_pkg.sv
package pulse_accum_pkg;

  typedef enum logic {
    PA_EVENT = 1'b0,
    PA_GATED = 1'b1
  } pa_mode_e;

  localparam int CLR_OVF  = 0;
  localparam int CLR_EDGE = 1;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } pa_pin_t;

endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge
  import pulse_accum_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pin_i,
  output pa_pin_t pin_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_chain
    if (g == 0) begin : g_first
      assign sync_d[g] = pin_i;
    end else begin : g_rest
      assign sync_d[g] = sync_q[g-1];
    end
  end

  always_comb begin
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    pin_o.level = sync_q[SYNC_STAGES-1];
    pin_o.rise  = sync_q[SYNC_STAGES-1] & ~prev_q;
    pin_o.fall  = ~sync_q[SYNC_STAGES-1] & prev_q;
  end

  AST_ONE_RISE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_o.rise |=> !pin_o.rise); // R2

endmodule

// File: rtl/pa_prescaler.sv
module pa_prescaler #(
  parameter int TICK_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] div_q, div_d;

  always_comb begin
    tick_o = (div_q == LAST);
    div_d  = tick_o ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  if (TICK_DIV > 1) begin : g_tick_chk
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o); // R5
  end

endmodule

// File: rtl/pa_counter.sv
module pa_counter
  import pulse_accum_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             pol_i,
  input  logic             tick_i,
  input  pa_pin_t          pin_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             edge_o
);

  pa_mode_e         mode;
  logic             ev_edge, gate_end, active, inc;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    mode     = pa_mode_e'(mode_i);
    ev_edge  = pol_i ? pin_i.fall : pin_i.rise;
    gate_end = pol_i ? pin_i.rise : pin_i.fall;
    active   = pin_i.level ^ pol_i;
    inc      = 1'b0;
    edge_o   = 1'b0;
    if (en_i) begin
      if (mode == PA_GATED) begin
        inc    = tick_i & active;
        edge_o = gate_end;
      end else begin
        inc    = ev_edge;
        edge_o = ev_edge;
      end
    end
    wrap_o = inc & ~wr_i & (cnt_q == '1);
    if (wr_i) begin
      cnt_d = wdata_i;
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cnt_q == $past(wdata_i))); // R8
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0)); // R6
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !wr_i) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pulse_accum_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TICK_DIV    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             enable_i,
  input  logic             mode_i,
  input  logic             pol_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic [1:0]       flag_clr_i,
  input  logic             ovf_ie_i,
  input  logic             edge_ie_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_flag_o,
  output logic             edge_flag_o,
  output logic             irq_o
);

  pa_pin_t pin_s;
  logic    tick, wrap, edge_hit;
  logic    ovf_q, ovf_d, edge_q, edge_d;

  pa_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .pin_o (pin_s)
  );

  pa_prescaler #(.TICK_DIV(TICK_DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  pa_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (enable_i),
    .mode_i  (mode_i),
    .pol_i   (pol_i),
    .tick_i  (tick),
    .pin_i   (pin_s),
    .wr_i    (cnt_wr_i),
    .wdata_i (cnt_wdata_i),
    .cnt_o   (cnt_o),
    .wrap_o  (wrap),
    .edge_o  (edge_hit)
  );

  always_comb begin
    ovf_d  = wrap     | (ovf_q  & ~flag_clr_i[CLR_OVF]);
    edge_d = edge_hit | (edge_q & ~flag_clr_i[CLR_EDGE]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      ovf_q  <= ovf_d;
      edge_q <= edge_d;
    end
  end

  assign ovf_flag_o  = ovf_q;
  assign edge_flag_o = edge_q;
  assign irq_o       = (ovf_q & ovf_ie_i) | (edge_q & edge_ie_i);

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !flag_clr_i[CLR_OVF]) |=> ovf_q); // R9
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q && !flag_clr_i[CLR_EDGE]) |=> edge_q); // R9
  AST_NO_EDGE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !edge_q) |=> !edge_q); // R11
  AST_NO_OVF_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !ovf_q) |=> !ovf_q); // R11

endmodule

// File: tb/pulse_accum_bench.sv
module pulse_accum_bench;

  localparam int SYNC = 2;
  localparam int DIV  = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin, en, mode, pol, wr, ovf_ie, edge_ie;
  logic [7:0] wdata;
  logic [1:0] clr;
  logic [7:0] cnt;
  logic       ovf_f, edge_f, irq;

  int    n_chk  = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    mdl_ok = 0;
  bit    done   = 0;

  int m_cnt, m_presc;
  bit m_ovf, m_edg, m_smp, m_prv, m_ev, m_end, m_inc, m_hit, m_wrap;
  bit hist[$];

  always #5 clk = ~clk;

  pulse_accum u_pulse_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin),
    .enable_i    (en),
    .mode_i      (mode),
    .pol_i       (pol),
    .cnt_wr_i    (wr),
    .cnt_wdata_i (wdata),
    .flag_clr_i  (clr),
    .ovf_ie_i    (ovf_ie),
    .edge_ie_i   (edge_ie),
    .cnt_o       (cnt),
    .ovf_flag_o  (ovf_f),
    .edge_flag_o (edge_f),
    .irq_o       (irq)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // Reference model: advanced on every rising clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_presc = 0; m_ovf = 0; m_edg = 0;
      hist.delete();
      for (int i = 0; i <= SYNC; i++) hist.push_back(1'b0);
      mdl_ok = 1;
    end else begin
      m_smp  = hist[SYNC-1];
      m_prv  = hist[SYNC];
      m_ev   = pol ? (!m_smp && m_prv) : (m_smp && !m_prv);
      m_end  = pol ? (m_smp && !m_prv) : (!m_smp && m_prv);
      m_inc  = en && (mode ? ((m_presc == DIV-1) && (m_smp != pol)) : m_ev);
      m_hit  = en && (mode ? m_end : m_ev);
      m_wrap = 0;
      if (wr) m_cnt = wdata;
      else if (m_inc) begin
        if (m_cnt == 255) m_wrap = 1;
        m_cnt = (m_cnt + 1) % 256;
      end
      m_ovf   = m_wrap || (m_ovf && !clr[0]);
      m_edg   = m_hit  || (m_edg && !clr[1]);
      m_presc = (m_presc + 1) % DIV;
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (mdl_ok && rst_n && !done) begin
      chk({cur_req, " cnt"},  int'(cnt),    m_cnt);
      chk({cur_req, " ovf"},  int'(ovf_f),  int'(m_ovf));
      chk({cur_req, " edge"}, int'(edge_f), int'(m_edg));
      chk({cur_req, " R10 irq"}, int'(irq),
          int'((m_ovf && ovf_ie) || (m_edg && edge_ie)));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input bit lvl, input int w, input int gap);
    pin = lvl; step(w);
    pin = ~lvl; step(gap);
  endtask

  task automatic load(input int v);
    wr = 1'b1; wdata = 8'(v); step(1);
    wr = 1'b0;
  endtask

  task automatic clear_flags();
    clr = 2'b11; step(1);
    clr = 2'b00;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pin = 0; en = 0; mode = 0; pol = 0; wr = 0;
    wdata = 0; clr = 0; ovf_ie = 0; edge_ie = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 cnt", int'(cnt), 0);
    chk("R1 flags", int'({ovf_f, edge_f}), 0);
    chk("R1 irq", int'(irq), 0);

    // R2 rising edges, three-edge latency
    cur_req = "R2"; en = 1;
    pin = 1; step(2);
    chk("R2 latency before", int'(cnt), 0);
    step(1);
    chk("R2 latency after", int'(cnt), 1);
    pin = 0; step(3);
    for (int i = 0; i < 4; i++) pulse(1'b1, 3, 3);
    step(4);
    chk("R2 five rises", int'(cnt), 5);
    chk("R7 edge flag event", int'(edge_f), 1);

    // R10 interrupt masking
    cur_req = "R10";
    edge_ie = 1; step(1);
    chk("R10 irq edge", int'(irq), 1);
    edge_ie = 0; step(1);
    chk("R10 irq masked", int'(irq), 0);
    clear_flags();
    chk("R9 edge cleared", int'(edge_f), 0);

    // R3 falling edges with polarity 1
    cur_req = "R3"; pol = 1; load(0);
    pin = 1; step(6);
    chk("R3 rise ignored", int'(cnt), 0);
    pin = 0; step(6);
    for (int i = 0; i < 2; i++) pulse(1'b1, 2, 4);
    step(3);
    chk("R3 three falls", int'(cnt), 3);

    // R6 preload 256-4, four events
    cur_req = "R6"; pol = 0; clear_flags(); load(252);
    for (int i = 0; i < 4; i++) pulse(1'b1, 3, 3);
    step(3);
    chk("R6 wrap count", int'(cnt), 0);
    chk("R6 ovf set", int'(ovf_f), 1);
    ovf_ie = 1; step(1);
    chk("R10 irq ovf", int'(irq), 1);

    // R9 set wins over clear in the same cycle
    cur_req = "R9"; load(255);
    pin = 1; step(2);
    clr = 2'b01; step(1); clr = 2'b00;
    chk("R9 set wins", int'(ovf_f), 1);
    pin = 0; step(3);
    clear_flags();
    chk("R9 ovf cleared", int'(ovf_f), 0);
    ovf_ie = 0;

    // R8 write beats increment, no overflow
    cur_req = "R8"; load(255);
    pin = 1; step(2);
    wr = 1; wdata = 8'h10; step(1); wr = 0;
    chk("R8 write wins", int'(cnt), 16);
    chk("R8 no ovf", int'(ovf_f), 0);
    pin = 0; step(3);

    // R11 disabled: count frozen, no flags, write works
    cur_req = "R11"; clear_flags(); en = 0;
    for (int i = 0; i < 3; i++) pulse(1'b1, 3, 3);
    step(3);
    chk("R11 count held", int'(cnt), 16);
    chk("R11 no edge flag", int'(edge_f), 0);
    load(7);
    chk("R11 write works", int'(cnt), 7);

    // R4 gated, active high: 640 active clocks -> 10 ticks
    cur_req = "R4"; en = 1; mode = 1; pol = 0; load(0);
    pin = 1; step(640);
    pin = 0; step(6);
    chk("R4 gated count", int'(cnt), 10);
    chk("R7 gate end flag", int'(edge_f), 1);
    clear_flags();
    // R4 short pulses: edges add nothing beyond ticks
    for (int i = 0; i < 40; i++) pulse(1'b1, 1, 3);
    step(4);

    // R5 free-running divider: two 64-clock windows -> +2
    cur_req = "R5"; load(0);
    pin = 1; step(64); pin = 0; step(37);
    pin = 1; step(64); pin = 0; step(6);
    chk("R5 two windows", int'(cnt), 2);

    // R4 gated active low, R7 end on rising edge
    cur_req = "R4"; clear_flags(); pol = 1; load(0); pin = 1; step(6);
    load(0);
    pin = 0; step(192); pin = 1; step(6);
    chk("R4 active low", int'(cnt), 3);
    chk("R7 end on rise", int'(edge_f), 1);

    // R6 gated overflow: 250 + 8 ticks
    cur_req = "R6"; pol = 0; clear_flags(); pin = 0; step(6); load(250);
    pin = 1; step(512); pin = 0; step(6);
    chk("R6 gated wrap cnt", int'(cnt), 2);
    chk("R6 gated ovf", int'(ovf_f), 1);

    step(4);
    finish_run();
  end

endmodule